// File: doc/BRIEF.md
# XOR Mixer with Nibble Popcount Accumulator

This block mixes a stream of one-bit receive samples, packed into words, with a local-oscillator bit pattern by XOR. It then counts how many bits of each mixed word are set. It does not use a full-width adder tree. It walks the mixed word one 4-bit nibble per clock, starting at the most significant nibble. Each nibble feeds a fixed lookup that bumps two small counters: a "twos" counter and a "ones" counter. The bit count seen so far always equals twice the twos count plus the ones count.

A divided-down sample strobe closes each accumulation window. The strobe snapshots the counter pair into an output register and clears the counters, and the pair is offered on a valid/ready output. An I/Q receiver uses two instances: one fed with the cosine pattern and one fed with the sine pattern. Word supply is paced by a ready signal, because each word takes one clock per nibble.

Top module: `xor_nibble_mixer`

## Requirements
- R1: Each accepted receive word is XORed bit by bit with the oscillator word presented in the same cycle. Only the XOR result is counted.
- R2: The mixed word is consumed one nibble per clock, starting with bits [WORD_W-1:WORD_W-4]. A word accepted at clock edge k has its nibbles counted at edges k+1 through k+WORD_W/4.
- R3: The lookup adds the following per nibble:
  - 0 set bits: nothing.
  - 1 set bit: 1 to ones.
  - 2 set bits: 1 to twos.
  - 3 set bits: 1 to twos and 1 to ones.
  - 4 set bits: 2 to twos.
- R4: A taken strobe loads the twos count onto `twosOut` and the ones count onto `onesOut`, raises `pairValid` on the next cycle, and clears both counters.
- R5: A strobe taken in the same cycle as a nibble step includes that nibble in the emitted pair. Counting afterwards restarts from zero.
- R6: Both counters are CNT_W bits wide and wrap modulo 2^CNT_W without any indication.
- R7: While `pairValid` is high and `pairReady` is low, `pairValid`, `twosOut` and `onesOut` hold their values.
- R8: A strobe arriving while a pair is pending and not being accepted is ignored. The counters are not cleared, and their counts carry into the next taken snapshot.
- R9: A strobe in the same cycle as an acceptance (`pairValid` and `pairReady` both high) takes a new snapshot, and `pairValid` stays high.
- R10: `wordReady` is high when no nibble remains or only the last nibble remains. A word is accepted when `wordValid` and `wordReady` are both high, so words can follow each other with no gap.
- R11: After reset, `pairValid` is low, `wordReady` is high, both outputs are zero and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxWord | input | WORD_W | Packed one-bit receive samples |
| loWord | input | WORD_W | Oscillator bit pattern matched to rxWord |
| wordValid | input | 1 | rxWord and loWord are offered |
| wordReady | output | 1 | Block can accept a word this cycle |
| sampleStrobe | input | 1 | Closes the current accumulation window |
| pairValid | output | 1 | A snapshot pair is on the outputs |
| pairReady | input | 1 | Consumer accepts the pair |
| twosOut | output | CNT_W | Snapshot of the twos counter |
| onesOut | output | CNT_W | Snapshot of the ones counter |

## Verification
Two pairs of functions can meet in one cycle. A strobe can land on a nibble step, and a strobe can land on the acceptance of a pending pair. The first case is provoked by raising the strobe on the cycle right after a word is loaded. Two mirrored words, one with its dense nibble first and one with it last, show both that the first nibble goes into the emitted pair and that the remaining nibbles start a fresh count. The second case is provoked by raising strobe and ready together while a pair is pending. It is judged by `pairValid` staying high with the counts gathered since the previous snapshot, including counts from a strobe that was ignored while the output stalled.

// File: rtl/mixpop_pkg.sv
package mixpop_pkg;

  localparam int NIB_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic stepNibble;
    logic takeSnapshot;
  } mixCtrlT;

  typedef struct packed {
    logic [1:0] twosInc;
    logic       onesInc;
  } nibIncT;

  // nibble weight split into a twos part and a ones part
  function automatic nibIncT nibbleLookup(input logic [NIB_W-1:0] nib);
    nibIncT     r;
    logic [2:0] bits;
    bits = '0;
    for (int b = 0; b < NIB_W; b++) bits = bits + {2'b00, nib[b]};
    r.twosInc = bits[2:1];
    r.onesInc = bits[0];
    return r;
  endfunction

endpackage

// File: rtl/mixpop_ctrl.sv
module mixpop_ctrl
  import mixpop_pkg::*;
#(
  parameter int NIBBLES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wordValid,
  input  logic    sampleStrobe,
  input  logic    pairReady,
  output logic    wordReady,
  output logic    pairValid,
  output mixCtrlT ctl
);

  localparam int LW = $clog2(NIBBLES + 1);

  logic [LW-1:0] nibLeft;

  assign wordReady        = (nibLeft <= LW'(1));
  assign ctl.loadWord     = wordValid && wordReady;
  assign ctl.stepNibble   = (nibLeft != '0);
  assign ctl.takeSnapshot = sampleStrobe && (!pairValid || pairReady);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibLeft <= '0;
    end else if (ctl.loadWord) begin
      nibLeft <= LW'(NIBBLES);
    end else if (ctl.stepNibble) begin
      nibLeft <= nibLeft - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairValid <= 1'b0;
    end else if (ctl.takeSnapshot) begin
      pairValid <= 1'b1;
    end else if (pairReady) begin
      pairValid <= 1'b0;
    end
  end

  assert_nib_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    nibLeft <= LW'(NIBBLES));

  assert_load_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=> !wordReady);

  assert_valid_from_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pairValid) |-> $past(sampleStrobe));

  assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairReady && sampleStrobe) |=> pairValid);

endmodule

// File: rtl/mixpop_dp.sv
module mixpop_dp
  import mixpop_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mixCtrlT           ctl,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] loWord,
  output logic [CNT_W-1:0]  twosOut,
  output logic [CNT_W-1:0]  onesOut
);

  logic [WORD_W-1:0] mixSh;
  logic [CNT_W-1:0]  twosCnt, onesCnt;
  logic [CNT_W-1:0]  twosNext, onesNext;
  nibIncT            inc;

  assign inc = nibbleLookup(mixSh[WORD_W-1 -: NIB_W]);

  always_comb begin
    twosNext = twosCnt;
    onesNext = onesCnt;
    if (ctl.stepNibble) begin
      twosNext = twosCnt + CNT_W'(inc.twosInc);
      onesNext = onesCnt + CNT_W'(inc.onesInc);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mixSh <= '0;
    end else if (ctl.loadWord) begin
      mixSh <= rxWord ^ loWord;
    end else if (ctl.stepNibble) begin
      mixSh <= mixSh << NIB_W;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      twosCnt <= '0;
      onesCnt <= '0;
      twosOut <= '0;
      onesOut <= '0;
    end else if (ctl.takeSnapshot) begin
      twosOut <= twosNext;
      onesOut <= onesNext;
      twosCnt <= '0;
      onesCnt <= '0;
    end else begin
      twosCnt <= twosNext;
      onesCnt <= onesNext;
    end
  end

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeSnapshot |=> (twosCnt == '0) && (onesCnt == '0));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stepNibble && !ctl.takeSnapshot) |=> ($stable(twosCnt) && $stable(onesCnt)));

endmodule

// File: rtl/xor_nibble_mixer.sv
module xor_nibble_mixer
  import mixpop_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] loWord,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic              sampleStrobe,
  output logic              pairValid,
  input  logic              pairReady,
  output logic [CNT_W-1:0]  twosOut,
  output logic [CNT_W-1:0]  onesOut
);

  localparam int NIBBLES = WORD_W / NIB_W;

  mixCtrlT ctl;

  mixpop_ctrl #(.NIBBLES(NIBBLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wordValid    (wordValid),
    .sampleStrobe (sampleStrobe),
    .pairReady    (pairReady),
    .wordReady    (wordReady),
    .pairValid    (pairValid),
    .ctl          (ctl)
  );

  mixpop_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rxWord  (rxWord),
    .loWord  (loWord),
    .twosOut (twosOut),
    .onesOut (onesOut)
  );

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairReady) |=> ($stable(twosOut) && $stable(onesOut)));

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairReady) |=> pairValid);

endmodule

// File: tb/test_xor_nibble_mixer.sv
`timescale 1ns/1ps
module test_xor_nibble_mixer;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;   // narrow so that wrap is reachable

  typedef struct packed {
    logic [31:0] rx;
    logic [31:0] lo;
    logic [7:0]  expTwos;
    logic [7:0]  expOnes;
  } vecT;

  localparam vecT VEC [9] = '{
    '{32'h00000000, 32'h00000000, 8'd0,  8'd0},
    '{32'hFFFFFFFF, 32'h00000000, 8'd16, 8'd0},
    '{32'h12481248, 32'h00000000, 8'd0,  8'd8},
    '{32'h3C3C3C3C, 32'h00000000, 8'd8,  8'd0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 8'd0,  8'd0},
    '{32'h7E000000, 32'h00000000, 8'd2,  8'd2},
    '{32'hA5A5A5A5, 32'h5A5A5A5A, 8'd16, 8'd0},
    '{32'h0000000F, 32'h00000001, 8'd1,  8'd1},
    '{32'h12345678, 32'h00000000, 8'd4,  8'd5}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [WORD_W-1:0] rxWord, loWord;
  logic              wordValid, wordReady, sampleStrobe, pairValid, pairReady;
  logic [CNT_W-1:0]  twosOut, onesOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xor_nibble_mixer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_xor_nibble_mixer (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .loWord(loWord),
    .wordValid(wordValid), .wordReady(wordReady), .sampleStrobe(sampleStrobe),
    .pairValid(pairValid), .pairReady(pairReady),
    .twosOut(twosOut), .onesOut(onesOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic loadWord(input logic [31:0] rx, input logic [31:0] lo);
    rxWord = rx; loWord = lo; wordValid = 1'b1;
    @(posedge clk); @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic drain();
    repeat (WORD_W / 4) @(negedge clk);
  endtask

  task automatic strobeCheck(input int expT, input int expO, input string req);
    sampleStrobe = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleStrobe = 1'b0;
    chk({req, " valid"}, int'(pairValid), 1);
    chk({req, " twos"}, int'(twosOut), expT);
    chk({req, " ones"}, int'(onesOut), expO);
    pairReady = 1'b1;
    @(posedge clk); @(negedge clk);
    pairReady = 1'b0;
    chk({req, " valid drop"}, int'(pairValid), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; rxWord = '0; loWord = '0;
    wordValid = 1'b0; sampleStrobe = 1'b0; pairReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 pairValid", int'(pairValid), 0);
    chk("R11 wordReady", int'(wordReady), 1);
    chk("R11 twos", int'(twosOut), 0);
    chk("R11 ones", int'(onesOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    strobeCheck(0, 0, "R11 counters zero");

    // table: R1 XOR, R3 lookup, R4 snapshot
    for (int i = 0; i < 9; i++) begin
      loadWord(VEC[i].rx, VEC[i].lo);
      drain();
      strobeCheck(int'(VEC[i].expTwos), int'(VEC[i].expOnes), "R1 R3 R4 table");
    end

    // R2 R5: strobe on first nibble step, dense nibble first
    loadWord(32'hF1000000, 32'h0);
    strobeCheck(2, 0, "R2 R5 first nibble");
    repeat (6) @(negedge clk);
    strobeCheck(0, 1, "R5 restart");
    // mirrored word: dense nibble last
    loadWord(32'h0000000F, 32'h0);
    strobeCheck(0, 0, "R2 msb first");
    repeat (6) @(negedge clk);
    strobeCheck(2, 0, "R2 last nibble");

    // R10: ready timing and back-to-back words
    loadWord(32'h0, 32'h0);
    chk("R10 busy", int'(wordReady), 0);
    repeat (7) @(negedge clk);
    chk("R10 last nibble ready", int'(wordReady), 1);
    loadWord(32'hFFFFFFFF, 32'h0);
    drain();
    strobeCheck(16, 0, "R10 back to back");

    // R7 hold, R8 ignored strobe, R9 strobe with accept
    loadWord(32'h11111111, 32'h0);
    drain();
    sampleStrobe = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleStrobe = 1'b0;
    loadWord(32'h33000000, 32'h0);
    drain();
    chk("R7 valid held", int'(pairValid), 1);
    chk("R7 twos held", int'(twosOut), 0);
    chk("R7 ones held", int'(onesOut), 8);
    sampleStrobe = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleStrobe = 1'b0;
    chk("R8 ignored twos", int'(twosOut), 0);
    chk("R8 ignored ones", int'(onesOut), 8);
    sampleStrobe = 1'b1; pairReady = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleStrobe = 1'b0; pairReady = 1'b0;
    chk("R9 valid stays", int'(pairValid), 1);
    chk("R9 R8 twos carried", int'(twosOut), 2);
    chk("R9 ones", int'(onesOut), 0);
    pairReady = 1'b1;
    @(posedge clk); @(negedge clk);
    pairReady = 1'b0;
    chk("R9 accepted", int'(pairValid), 0);

    // R6: wrap with 5-bit counters
    loadWord(32'hFFFFFFFF, 32'h0); drain();
    loadWord(32'hFFFFFFFF, 32'h0); drain();
    loadWord(32'h0000000F, 32'h0); drain();
    strobeCheck(2, 0, "R6 twos wrap");
    for (int k = 0; k < 4; k++) begin
      loadWord(32'h11111111, 32'h0); drain();
    end
    loadWord(32'h00000001, 32'h0); drain();
    strobeCheck(0, 1, "R6 ones wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule